// File: doc/BRIEF.md
# Register Dependency Interlock for an Eight-Stage In-Order Pipeline

This block tracks the in-flight instructions of an in-order pipeline with the stages F1, F2, D1, D2, R1, R2, E and W. It finds read-after-write register dependencies and stalls the front of the pipeline until they are resolved. Every instruction enters F1 with an identifier and four register bitmasks, one bit per architectural register. Two masks say which registers it reads in its D2 cycle and which in its E cycle. The other two say which registers it writes in D2 and which in E. Decoding opcodes into these masks happens upstream.

The unit compares the masks of the instruction in D2 with those of the valid instructions in R1, R2 and E. A dependency needs a wait only if the consumer would read a register before the producer has written it. In practice that means a D2 read of a register that an older instruction writes in E. While a wait is needed, F1 through D2 hold their contents and R1 takes an empty slot. Identifiers leave W in program order, so the hold and the empty slots can be seen at the ports. A flush input empties the whole pipeline.

Top module: `ilk_interlock`

## Requirements
- R1: During and after a synchronous active-low reset, no stage holds an instruction: `stall` and `bubble` are 0, `in_ready` is 1 and `wb_valid` is 0.
- R2: An instruction in D2 whose D2-read mask overlaps the E-write mask of a valid older instruction stalls until that producer has left E. This costs 3 cycles if the producer is in R1, 2 cycles if it is in R2, 1 cycle if it is in E, and none if the consumer follows the producer by three or more instructions.
- R3: A register written in E and read in E by the next instruction causes no stall.
- R4: A register written in D2 causes no stall for any later reader, whether that reader reads it in D2 or in E.
- R5: Each mask bit is an independent register. Bit 0 (low accumulator half) and bit 1 (high accumulator half) never interact: an E-write of bit 0 does not stall a D2-read of bit 1.
- R6: In a stall cycle, `in_ready` is 0 and the presented instruction is not taken. F1 to D2 keep their instructions. `bubble` is 1 and R1 receives an empty slot, which reaches W four cycles later as a cycle with `wb_valid` = 0.
- R7: Every accepted instruction leaves W exactly once, in acceptance order, with its identifier on `wb_id`. With no stall, this happens seven cycles after the clock edge that accepted it.
- R8: While `flush` is 1, `stall` and `bubble` are 0. At that clock edge every stage is emptied, including the instruction presented in that cycle.
- R9: Empty slots never cause a stall. A second D2-reader of the same register that directly follows a stalled reader needs no further stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empties every stage at the next edge |
| in_valid | input | 1 | An instruction is presented to F1 |
| in_id | input | ID_W | Identifier of the presented instruction |
| in_rd_d2 | input | NREG | Registers read in D2 |
| in_rd_e | input | NREG | Registers read in E |
| in_wr_d2 | input | NREG | Registers written in D2 |
| in_wr_e | input | NREG | Registers written in E |
| in_ready | output | 1 | The presented instruction is taken at the next edge |
| stall | output | 1 | F1 to D2 hold this cycle |
| bubble | output | 1 | An empty slot is sent into R1 this cycle |
| wb_valid | output | 1 | The W stage holds an instruction |
| wb_id | output | ID_W | Identifier of the instruction in W |

## Verification
The bench builds the unit with NREG = 4 and ID_W = 8. With only four registers, random masks of low density collide often. Random traffic therefore reaches chains of dependent producers, overlapping stall windows and flushes that land in the middle of a stall. Directed sequences use bits 0 and 1 as the two accumulator halves. Eight-bit identifiers stay distinct across the whole pipeline, so any reordering or duplicate shows up on `wb_id`.

// File: rtl/ilk_pkg.sv
// Package: stage numbering and the rule that decides whether a producer
// still ahead of the consumer has yet to write a register the consumer reads.
// Assumes the consumer is always examined while it sits in D2.
package ilk_pkg;

    localparam int NST   = 8;
    localparam int ST_F1 = 0;
    localparam int ST_F2 = 1;
    localparam int ST_D1 = 2;
    localparam int ST_D2 = 3;
    localparam int ST_R1 = 4;
    localparam int ST_R2 = 5;
    localparam int ST_E  = 6;
    localparam int ST_W  = 7;

    // producers are the stages between the consumer and write-back
    localparam int NPROD = ST_E - ST_R1 + 1;
    // access phases: 0 = D2, 1 = E
    localparam int NPH   = 2;

    // stage in which an access of the given phase takes place
    function automatic int phase_stage(input int ph);
        return (ph == 0) ? ST_D2 : ST_E;
    endfunction

    // true when a producer now in prod_st will not have written by the time
    // a consumer now in D2 performs its read at stage rd_at
    function automatic logic late_write(input int rd_at, input int wr_at,
                                        input int prod_st);
        return (prod_st + (rd_at - ST_D2)) <= wr_at;
    endfunction

endpackage

// File: rtl/ilk_stage.sv
// One pipeline slot: a valid bit plus a payload of width W.
// Hold keeps the slot, bubble loads an empty slot with cleared payload,
// reset and flush empty it. Hold has priority over bubble.
module ilk_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         hold,
    input  logic         bubble,
    input  logic         d_valid,
    input  logic [W-1:0] d_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);

    // slot register: empty, held, emptied by a bubble, or loaded
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else if (hold) begin
            q_valid <= q_valid;
            q_data  <= q_data;
        end else if (bubble) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= d_valid;
            q_data  <= d_data;
        end
    end

endmodule

// File: rtl/ilk_hazard.sv
// Dependency comparator: for each producer stage (R1, R2, E) and each pair
// of read phase and write phase, flags a match when the rule in ilk_pkg says
// the write lands too late for the read. Assumes masks of empty slots may be
// anything: the valid bits gate every match.
module ilk_hazard
    import ilk_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic             cons_valid,
    input  logic [NREG-1:0]  cons_rd_d2,
    input  logic [NREG-1:0]  cons_rd_e,
    input  logic [NPROD-1:0] prod_valid,
    input  logic [NREG-1:0]  prod_wr_d2 [NPROD],
    input  logic [NREG-1:0]  prod_wr_e  [NPROD],
    output logic [NPROD-1:0] prod_hit
);

    for (genvar k = 0; k < NPROD; k++) begin : g_prod
        logic [NPH*NPH-1:0] pair;
        for (genvar pr = 0; pr < NPH; pr++) begin : g_rd
            for (genvar pw = 0; pw < NPH; pw++) begin : g_wr
                localparam logic NEED =
                    late_write(phase_stage(pr), phase_stage(pw), ST_R1 + k);
                logic [NREG-1:0] rmask;
                logic [NREG-1:0] wmask;
                // pick the consumer read mask of this phase
                assign rmask = (pr == 0) ? cons_rd_d2 : cons_rd_e;
                // pick the producer write mask of this phase
                assign wmask = (pw == 0) ? prod_wr_d2[k] : prod_wr_e[k];
                // overlap only counts where the timing rule calls for a wait
                assign pair[pr*NPH+pw] = NEED && cons_valid && prod_valid[k]
                                         && (|(rmask & wmask));
            end
        end
        // any phase pair of this producer is enough
        assign prod_hit[k] = |pair;
    end

endmodule

// File: rtl/ilk_interlock.sv
// Top: eight slots F1..W with per-slot tag payloads, and the comparator that
// drives the stall. Read masks are kept only up to D2 and write masks only up
// to E, since nothing looks at them later. Assumes the consumer under test is
// the D2 instruction and that all older instructions are in R1..W.
module ilk_interlock
    import ilk_pkg::*;
#(
    parameter int NREG = 8,
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            in_valid,
    input  logic [ID_W-1:0] in_id,
    input  logic [NREG-1:0] in_rd_d2,
    input  logic [NREG-1:0] in_rd_e,
    input  logic [NREG-1:0] in_wr_d2,
    input  logic [NREG-1:0] in_wr_e,
    output logic            in_ready,
    output logic            stall,
    output logic            bubble,
    output logic            wb_valid,
    output logic [ID_W-1:0] wb_id
);

    localparam int FRONT_W = ID_W + 4 * NREG;
    localparam int BACK_W  = ID_W + 2 * NREG;

    logic [NST-1:0]  fv;
    logic [ID_W-1:0] fid  [NST];
    logic [NREG-1:0] frd2 [ST_D2+1];
    logic [NREG-1:0] frde [ST_D2+1];
    logic [NREG-1:0] fwd2 [ST_E+1];
    logic [NREG-1:0] fwe  [ST_E+1];

    logic [NREG-1:0]  pw2 [NPROD];
    logic [NREG-1:0]  pwe [NPROD];
    logic [NPROD-1:0] pvalid;
    logic [NPROD-1:0] phit;
    logic             hazard;

    // slice producer tags out of R1..E for the comparator
    for (genvar k = 0; k < NPROD; k++) begin : g_pslice
        assign pw2[k]    = fwd2[ST_R1+k];
        assign pwe[k]    = fwe[ST_R1+k];
        assign pvalid[k] = fv[ST_R1+k];
    end

    ilk_hazard #(.NREG(NREG)) u_hazard (
        .cons_valid (fv[ST_D2]),
        .cons_rd_d2 (frd2[ST_D2]),
        .cons_rd_e  (frde[ST_D2]),
        .prod_valid (pvalid),
        .prod_wr_d2 (pw2),
        .prod_wr_e  (pwe),
        .prod_hit   (phit)
    );

    // any late producer stalls, except in a flush cycle
    assign hazard   = |phit;
    assign stall    = hazard && !flush;
    assign bubble   = stall;
    assign in_ready = !stall;

    for (genvar s = 0; s < NST; s++) begin : g_slot
        logic hold_s;
        logic bub_s;
        logic dv;
        // front slots hold while stalled; R1 takes the empty slot
        assign hold_s = (s <= ST_D2) ? stall : 1'b0;
        assign bub_s  = (s == ST_R1) ? stall : 1'b0;

        if (s == ST_F1) begin : g_dv_in
            assign dv = in_valid;
        end else begin : g_dv_prev
            assign dv = fv[s-1];
        end

        if (s <= ST_D2) begin : g_front
            logic [FRONT_W-1:0] d;
            logic [FRONT_W-1:0] q;
            if (s == ST_F1) begin : g_src_in
                assign d = {in_id, in_rd_d2, in_rd_e, in_wr_d2, in_wr_e};
            end else begin : g_src_prev
                assign d = {fid[s-1], frd2[s-1], frde[s-1], fwd2[s-1], fwe[s-1]};
            end
            ilk_stage #(.W(FRONT_W)) u_stage (
                .clk(clk), .rst_n(rst_n), .flush(flush), .hold(hold_s),
                .bubble(bub_s), .d_valid(dv), .d_data(d),
                .q_valid(fv[s]), .q_data(q)
            );
            assign {fid[s], frd2[s], frde[s], fwd2[s], fwe[s]} = q;
        end else if (s <= ST_E) begin : g_back
            logic [BACK_W-1:0] d;
            logic [BACK_W-1:0] q;
            assign d = {fid[s-1], fwd2[s-1], fwe[s-1]};
            ilk_stage #(.W(BACK_W)) u_stage (
                .clk(clk), .rst_n(rst_n), .flush(flush), .hold(hold_s),
                .bubble(bub_s), .d_valid(dv), .d_data(d),
                .q_valid(fv[s]), .q_data(q)
            );
            assign {fid[s], fwd2[s], fwe[s]} = q;
        end else begin : g_wb
            ilk_stage #(.W(ID_W)) u_stage (
                .clk(clk), .rst_n(rst_n), .flush(flush), .hold(hold_s),
                .bubble(bub_s), .d_valid(dv), .d_data(fid[s-1]),
                .q_valid(fv[s]), .q_data(fid[s])
            );
        end
    end

    // write-back slot is visible at the ports
    assign wb_valid = fv[ST_W];
    assign wb_id    = fid[ST_W];

endmodule

// File: rtl/ilk_interlock_chk.sv
// Checker: temporal properties of the interlock, bound to every instance of
// ilk_interlock. Assumes the stage valid vector is ordered F1 (bit 0) to W.
module ilk_interlock_chk #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic            stall,
    input logic            bubble,
    input logic            in_ready,
    input logic            wb_valid,
    input logic [7:0]      st_valid,
    input logic [ID_W-1:0] d2_id
);

    logic [1:0] run;

    // length of the current run of stall cycles so far
    always_ff @(posedge clk) begin
        if (!rst_n) run <= '0;
        else if (stall && run != 2'd3) run <= run + 2'd1;
        else if (!stall) run <= '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!stall && !bubble && in_ready && !wb_valid)); // R1

    AST_STALL_RUN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (run < 2'd3)); // R2

    AST_STALL_HAS_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (st_valid[3] && (|st_valid[6:4]))); // R9

    AST_D2_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (st_valid[3] && $stable(d2_id))); // R6

    AST_BUBBLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> ##4 !wb_valid); // R6

    AST_FLUSH_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!stall && !bubble)); // R8

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_valid == 8'd0)); // R8

endmodule

bind ilk_interlock ilk_interlock_chk #(.ID_W(ID_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .stall    (stall),
    .bubble   (bubble),
    .in_ready (in_ready),
    .wb_valid (wb_valid),
    .st_valid (fv),
    .d2_id    (fid[ilk_pkg::ST_D2])
);

// File: tb/ilk_interlock_test.sv
// Bench: directed dependency cases plus seeded random traffic, compared every
// cycle against a slot-level model built from the requirements.
module ilk_interlock_test;

    localparam int NR = 4;
    localparam int IW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          drv_rst_n = 1'b0;
    logic          drv_flush = 1'b0;
    logic          drv_valid = 1'b0;
    logic [IW-1:0] drv_id = '0;
    logic [NR-1:0] drv_r2 = '0, drv_re = '0, drv_w2 = '0, drv_we = '0;

    logic          in_ready, stall, bubble, wb_valid;
    logic [IW-1:0] wb_id;

    ilk_interlock #(.NREG(NR), .ID_W(IW)) uut (
        .clk(clk), .rst_n(drv_rst_n), .flush(drv_flush),
        .in_valid(drv_valid), .in_id(drv_id),
        .in_rd_d2(drv_r2), .in_rd_e(drv_re), .in_wr_d2(drv_w2), .in_wr_e(drv_we),
        .in_ready(in_ready), .stall(stall), .bubble(bubble),
        .wb_valid(wb_valid), .wb_id(wb_id)
    );

    int total = 0;
    int bad = 0;
    int stall_total = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;
    logic [IW-1:0] next_id = 8'd1;

    // model state, index 0 = F1 ... 7 = W
    bit          mv  [8];
    bit [IW-1:0] mid [8];
    bit [NR-1:0] mr2 [8];
    bit [NR-1:0] mw2 [8];
    bit [NR-1:0] mwe [8];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // wait needed: D2 reader against an E writer still in R1, R2 or E
    function automatic bit model_hz();
        bit h = 1'b0;
        for (int s = 4; s <= 6; s++)
            if (mv[s] && ((mr2[3] & mwe[s]) != '0)) h = 1'b1;
        return mv[3] && h;
    endfunction

    // compare ports with the model, then advance the model over the next edge
    always @(negedge clk) begin
        bit hz;
        bit es;
        hz = model_hz();
        es = hz && !drv_flush && drv_rst_n;
        if (stall) stall_total++;
        if (chk_en) begin
            chk(stall == es, "R2 stall", int'(stall), int'(es));
            chk(bubble == es, "R6 bubble", int'(bubble), int'(es));
            chk(in_ready == !es, "R6 in_ready", int'(in_ready), int'(!es));
            chk(wb_valid == mv[7], "R7 wb_valid", int'(wb_valid), int'(mv[7]));
            if (mv[7]) chk(wb_id == mid[7], "R7 wb_id", int'(wb_id), int'(mid[7]));
        end
        if (!drv_rst_n || drv_flush) begin
            for (int s = 0; s < 8; s++) begin
                mv[s] = 0; mid[s] = '0; mr2[s] = '0; mw2[s] = '0; mwe[s] = '0;
            end
        end else begin
            mv[7] = mv[6]; mid[7] = mid[6];
            for (int s = 6; s >= 5; s--) begin
                mv[s] = mv[s-1]; mid[s] = mid[s-1]; mw2[s] = mw2[s-1]; mwe[s] = mwe[s-1];
            end
            if (hz) begin
                mv[4] = 0; mid[4] = '0; mw2[4] = '0; mwe[4] = '0;
            end else begin
                mv[4] = mv[3]; mid[4] = mid[3]; mw2[4] = mw2[3]; mwe[4] = mwe[3];
                for (int s = 3; s >= 1; s--) begin
                    mv[s] = mv[s-1]; mid[s] = mid[s-1]; mr2[s] = mr2[s-1];
                    mw2[s] = mw2[s-1]; mwe[s] = mwe[s-1];
                end
                mv[0] = drv_valid; mid[0] = drv_id; mr2[0] = drv_r2;
                mw2[0] = drv_w2; mwe[0] = drv_we;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // present one instruction until it is taken
    task automatic issue(input [NR-1:0] r2, input [NR-1:0] re,
                         input [NR-1:0] w2, input [NR-1:0] we);
        bit acc;
        drv_valid = 1'b1; drv_id = next_id; next_id++;
        drv_r2 = r2; drv_re = re; drv_w2 = w2; drv_we = we;
        do begin
            @(negedge clk);
            acc = in_ready;
            step();
        end while (!acc);
        drv_valid = 1'b0; drv_r2 = '0; drv_re = '0; drv_w2 = '0; drv_we = '0;
    endtask

    // producer, gap of empty-mask instructions, consumer; count the stalls
    task automatic dep_case(input string tag, input [NR-1:0] w2, input [NR-1:0] we,
                            input int gap, input [NR-1:0] r2, input [NR-1:0] re,
                            input int exp);
        int base;
        base = stall_total;
        issue('0, '0, w2, we);
        for (int g = 0; g < gap; g++) issue('0, '0, '0, '0);
        issue(r2, re, '0, '0);
        repeat (14) step();
        chk((stall_total - base) == exp, tag, stall_total - base, exp);
    endtask

    initial begin
        int base;
        bit pend;
        bit acc;
        void'($urandom(32'd2024));
        repeat (3) step();
        // R1: reset state at the ports
        chk(stall == 1'b0 && bubble == 1'b0, "R1 stall/bubble in reset", int'(stall | bubble), 0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        chk(wb_valid == 1'b0, "R1 wb_valid in reset", int'(wb_valid), 0);
        drv_rst_n = 1'b1;
        chk_en = 1'b1;
        step();

        dep_case("R2 E-write then D2-read, adjacent", '0, 4'b0100, 0, 4'b0100, '0, 3);
        dep_case("R2 E-write then D2-read, gap 1",    '0, 4'b0100, 1, 4'b0100, '0, 2);
        dep_case("R2 E-write then D2-read, gap 2",    '0, 4'b0100, 2, 4'b0100, '0, 1);
        dep_case("R2 E-write then D2-read, gap 3",    '0, 4'b0100, 3, 4'b0100, '0, 0);
        dep_case("R3 E-write then E-read",            '0, 4'b0001, 0, '0, 4'b0001, 0);
        dep_case("R4 D2-write then D2-read",          4'b1000, '0, 0, 4'b1000, '0, 0);
        dep_case("R4 D2-write then E-read",           4'b1000, '0, 0, '0, 4'b1000, 0);
        dep_case("R5 low half written, high half read", '0, 4'b0001, 0, 4'b0010, '0, 0);
        dep_case("R5 low half written, low half read",  '0, 4'b0001, 0, 4'b0001, '0, 3);

        // R9: two D2 readers in a row after one E writer cost three in total
        base = stall_total;
        issue('0, '0, '0, 4'b0010);
        issue(4'b0010, '0, '0, '0);
        issue(4'b0010, '0, '0, '0);
        repeat (14) step();
        chk((stall_total - base) == 3, "R9 second reader after bubbles", stall_total - base, 3);

        // R8: flush in the middle of a stall releases it and empties the pipe
        issue('0, '0, '0, 4'b0001);
        issue(4'b0001, '0, '0, '0);
        repeat (4) step();
        drv_flush = 1'b1;
        @(negedge clk);
        chk(stall == 1'b0, "R8 stall released by flush", int'(stall), 0);
        step();
        drv_flush = 1'b0;
        base = stall_total;
        repeat (10) begin
            @(negedge clk);
            chk(wb_valid == 1'b0, "R8 pipeline empty after flush", int'(wb_valid), 0);
            step();
        end
        chk(stall_total == base, "R8 no stall after flush", stall_total - base, 0);

        // random traffic against the model
        pend = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (!pend) begin
                drv_valid = ($urandom % 4) != 0;
                drv_id = next_id; next_id++;
                drv_r2 = NR'($urandom & $urandom);
                drv_re = NR'($urandom & $urandom);
                drv_w2 = NR'($urandom & $urandom);
                drv_we = NR'($urandom & $urandom);
            end
            drv_flush = ($urandom % 60) == 0;
            @(negedge clk);
            acc = drv_valid && in_ready && !drv_flush;
            step();
            pend = drv_valid && !acc && !drv_flush;
        end
        drv_flush = 1'b0; drv_valid = 1'b0;
        repeat (12) step();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule